// File: doc/BRIEF.md
# Cascaded Bus Clock Prescaler

This block produces the single-cycle clock-enable strobes for three bus domains that run off one system clock. The fast bus enable comes from the system clock through a programmable ratio. The two peripheral bus enables come from the fast bus enable through ratios of their own. Each peripheral divider counts fast bus strobes, not raw clock cycles. Logic in each domain stays on the system clock and advances only in cycles where its strobe is high.

Software writes the ratio codes through a small write port: a write strobe, a 2-bit field select and a 4-bit data word. A written code waits in a configuration register. The divider it controls takes it up only when the divided period in progress completes, so a change never cuts a period short or stretches one.

Top module: `bus_clk_presc`

## Requirements
- R1: While reset is held and in the first cycles after it, every ratio is 1, so `sys_en_o`, `pa_en_o` and `pb_en_o` are all high.
- R2: The fast bus code is the 4-bit value written with select 0. When bit 3 is 0 the ratio is 1. Codes 8 to 15 select ratios 2, 4, 8, 16, 64, 128, 256 and 512 in that order, so divide-by-32 is not available.
- R3: A peripheral code is bits 2:0 of the data written with select 1 (peripheral A) or select 2 (peripheral B). When bit 2 is 0 the ratio is 1. Codes 4 to 7 select ratios 2, 4, 8 and 16.
- R4: With a fast bus ratio N above 1, `sys_en_o` is high for exactly one cycle in every N cycles.
- R5: With a peripheral ratio M, that peripheral's enable is high on every M-th assertion of `sys_en_o`. The count does not depend on raw clock cycles.
- R6: `pa_en_o` and `pb_en_o` are high only in cycles where `sys_en_o` is also high.
- R7: A newly written ratio takes effect only after the period already under way finishes. The next period then uses the new ratio in full.
- R8: While a divider's ratio is 1, its enable follows its input without gaps. `sys_en_o` stays high, and a peripheral enable equals `sys_en_o`.
- R9: A write with select 3 changes no ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 2 | Field select: 0 fast bus, 1 peripheral A, 2 peripheral B, 3 unused |
| cfg_data_i | input | 4 | Ratio code being written |
| sys_en_o | output | 1 | Fast bus enable strobe |
| pa_en_o | output | 1 | Peripheral A enable strobe |
| pb_en_o | output | 1 | Peripheral B enable strobe |

## Verification
The hardest case to reach is a ratio change that lands inside a long period. This happens when the fast bus divides by a large ratio and a peripheral divides that result again, so the peripheral period is thousands of cycles long. The stimulus writes new codes at arbitrary points inside such periods. It rewrites a code several times before the period ends, and it also writes in the very cycle a period completes. A behavioural model of remaining-count integers is compared on every clock. It shows that only the last code written before each boundary is applied, and that the 64 ratio follows 16 with no 32 between them.

// File: rtl/presc_pkg.sv
package presc_pkg;
  localparam int SYS_CODE_W    = 4;
  localparam int PER_CODE_W    = 3;
  localparam int SYS_SHIFT_MAX = 9;
  localparam int PER_SHIFT_MAX = 4;
  localparam int SYS_SHIFT_W   = $clog2(SYS_SHIFT_MAX + 1);
  localparam int PER_SHIFT_W   = $clog2(PER_SHIFT_MAX + 1);
  localparam int N_PER         = 2;
  localparam int SEL_W         = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_SYS  = 2'd0,
    SEL_PA   = 2'd1,
    SEL_PB   = 2'd2,
    SEL_NONE = 2'd3
  } cfg_sel_e;

  // code -> log2(ratio); index 4 and up skip one step (no /32)
  function automatic logic [SYS_SHIFT_W-1:0] sys_shift(input logic [SYS_CODE_W-1:0] code);
    logic [SYS_SHIFT_W-1:0] s;
    if (!code[SYS_CODE_W-1]) begin
      s = '0;
    end else begin
      s = SYS_SHIFT_W'(code[SYS_CODE_W-2:0]) + SYS_SHIFT_W'(1);
      if (code[SYS_CODE_W-2]) s = s + SYS_SHIFT_W'(1);
    end
    return s;
  endfunction

  function automatic logic [PER_SHIFT_W-1:0] per_shift(input logic [PER_CODE_W-1:0] code);
    logic [PER_SHIFT_W-1:0] s;
    if (!code[PER_CODE_W-1]) s = '0;
    else s = PER_SHIFT_W'(code[PER_CODE_W-2:0]) + PER_SHIFT_W'(1);
    return s;
  endfunction
endpackage

// File: rtl/presc_cfg.sv
module presc_cfg
  import presc_pkg::*;
(
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cfg_we_i,
  input  logic [SEL_W-1:0]        cfg_sel_i,
  input  logic [SYS_CODE_W-1:0]   cfg_data_i,
  output logic [SYS_SHIFT_W-1:0]  sys_shift_o,
  output logic [PER_SHIFT_W-1:0]  per_shift_o [N_PER]
);
  logic [SYS_CODE_W-1:0] sys_code_q;
  logic [PER_CODE_W-1:0] per_code_q [N_PER];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sys_code_q <= '0;
    else if (cfg_we_i && cfg_sel_i == SEL_SYS) sys_code_q <= cfg_data_i;
  end

  assign sys_shift_o = sys_shift(sys_code_q);

  for (genvar i = 0; i < N_PER; i++) begin : g_per
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) per_code_q[i] <= '0;
      else if (cfg_we_i && cfg_sel_i == SEL_W'(i + 1))
        per_code_q[i] <= cfg_data_i[PER_CODE_W-1:0];
    end
    assign per_shift_o[i] = per_shift(per_code_q[i]);

    // R9
    per_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cfg_we_i && cfg_sel_i == SEL_NONE) |=> $stable(per_code_q[i]));
  end

  // R9
  sys_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_sel_i == SEL_NONE) |=> $stable(sys_code_q));

  // R2
  sys_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_sel_i == SEL_SYS) |=> sys_code_q == $past(cfg_data_i));
endmodule

// File: rtl/presc_stage.sv
module presc_stage #(
  parameter int MAX_SHIFT = 9
) (
  input  logic                                  clk_i,
  input  logic                                  rst_ni,
  input  logic                                  tick_i,
  input  logic [$clog2(MAX_SHIFT+1)-1:0]        shift_i,
  output logic                                  en_o
);
  localparam int SHW   = $clog2(MAX_SHIFT + 1);
  localparam int CNT_W = (MAX_SHIFT > 0) ? MAX_SHIFT : 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last;
  logic [SHW-1:0]   cur_q;
  logic             wrap;

  assign last = ~({CNT_W{1'b1}} << cur_q);
  assign wrap = (cnt_q == last);
  assign en_o = tick_i & wrap;

  // ratio sampled only at period end
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      cur_q <= '0;
    end else if (tick_i) begin
      if (wrap) begin
        cnt_q <= '0;
        cur_q <= shift_i;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R7
  ratio_switch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cur_q) |-> $past(en_o));

  // R4
  single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_o && shift_i != '0) |=> !en_o);

  // R4
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= last);

  // R8
  ratio_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_q == '0) |-> (en_o == tick_i));
endmodule

// File: rtl/bus_clk_presc.sv
module bus_clk_presc
  import presc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cfg_we_i,
  input  logic [1:0] cfg_sel_i,
  input  logic [3:0] cfg_data_i,
  output logic       sys_en_o,
  output logic       pa_en_o,
  output logic       pb_en_o
);
  logic [SYS_SHIFT_W-1:0] sys_shift_w;
  logic [PER_SHIFT_W-1:0] per_shift_w [N_PER];
  logic [N_PER-1:0]       per_en;
  logic                   sys_en;

  presc_cfg u_cfg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_we_i    (cfg_we_i),
    .cfg_sel_i   (cfg_sel_i),
    .cfg_data_i  (cfg_data_i),
    .sys_shift_o (sys_shift_w),
    .per_shift_o (per_shift_w)
  );

  presc_stage #(.MAX_SHIFT(SYS_SHIFT_MAX)) u_sys (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (1'b1),
    .shift_i (sys_shift_w),
    .en_o    (sys_en)
  );

  for (genvar i = 0; i < N_PER; i++) begin : g_per
    presc_stage #(.MAX_SHIFT(PER_SHIFT_MAX)) u_per (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .tick_i  (sys_en),
      .shift_i (per_shift_w[i]),
      .en_o    (per_en[i])
    );

    // R6
    per_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      per_en[i] |-> sys_en);
  end

  assign sys_en_o = sys_en;
  assign pa_en_o  = per_en[0];
  assign pb_en_o  = per_en[1];
endmodule

// File: tb/bus_clk_presc_tb.sv
module bus_clk_presc_tb;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cfg_we_i = 1'b0;
  logic [1:0] cfg_sel_i = 2'd0;
  logic [3:0] cfg_data_i = 4'd0;
  logic       sys_en_o, pa_en_o, pb_en_o;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  bit run_cmp = 1'b0;
  string phase = "R1";

  // reference state: cycles left in current period, pending codes
  int sys_rem = 1;
  int per_rem [2] = '{1, 1};
  int sys_code = 0;
  int per_code [2] = '{0, 0};

  always #2.5 clk = ~clk;

  bus_clk_presc u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .cfg_we_i   (cfg_we_i),
    .cfg_sel_i  (cfg_sel_i),
    .cfg_data_i (cfg_data_i),
    .sys_en_o   (sys_en_o),
    .pa_en_o    (pa_en_o),
    .pb_en_o    (pb_en_o)
  );

  function automatic int sys_ratio(int code);
    if (code < 8) return 1;
    case (code)
      8: return 2;    9: return 4;    10: return 8;   11: return 16;
      12: return 64;  13: return 128; 14: return 256; default: return 512;
    endcase
  endfunction

  function automatic int per_ratio(int code);
    if (code < 4) return 1;
    case (code)
      4: return 2; 5: return 4; 6: return 8; default: return 16;
    endcase
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      sys_rem = 1; per_rem = '{1, 1}; sys_code = 0; per_code = '{0, 0};
    end else begin
      if (sys_rem == 1) begin
        for (int i = 0; i < 2; i++)
          per_rem[i] = (per_rem[i] == 1) ? per_ratio(per_code[i]) : per_rem[i] - 1;
        sys_rem = sys_ratio(sys_code);
      end else begin
        sys_rem = sys_rem - 1;
      end
      if (cfg_we_i) begin
        if (cfg_sel_i == 2'd0) sys_code = int'(cfg_data_i);
        else if (cfg_sel_i == 2'd1) per_code[0] = int'(cfg_data_i[2:0]);
        else if (cfg_sel_i == 2'd2) per_code[1] = int'(cfg_data_i[2:0]);
      end
    end
  end

  task automatic chk(string req, string nm, logic act, logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s at cycle %0d: actual %b expected %b", req, nm, cyc, act, exp);
    end
  endtask

  // every-cycle comparison: R4 on the fast strobe, R5 on peripherals, R6 gating
  always @(negedge clk) begin
    cyc++;
    if (run_cmp && rst_ni) begin
      chk({phase, "/R4"}, "sys_en_o", sys_en_o, sys_rem == 1);
      chk({phase, "/R5"}, "pa_en_o", pa_en_o, (sys_rem == 1) && (per_rem[0] == 1));
      chk({phase, "/R5"}, "pb_en_o", pb_en_o, (sys_rem == 1) && (per_rem[1] == 1));
      chk("R6", "pa_en_o&!sys_en_o", pa_en_o & ~sys_en_o, 1'b0);
      chk("R6", "pb_en_o&!sys_en_o", pb_en_o & ~sys_en_o, 1'b0);
    end
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog: actual cycle %0d expected below 150000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic wr(logic [1:0] sel, logic [3:0] data);
    @(negedge clk);
    cfg_we_i = 1'b1; cfg_sel_i = sel; cfg_data_i = data;
    @(negedge clk);
    cfg_we_i = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    idle(2);
    // R1: enables high while in reset
    chk("R1", "sys_en_o", sys_en_o, 1'b1);
    chk("R1", "pa_en_o", pa_en_o, 1'b1);
    chk("R1", "pb_en_o", pb_en_o, 1'b1);
    rst_ni = 1'b1;
    run_cmp = 1'b1;
    idle(3);
    phase = "R8";
    for (int k = 0; k < 5; k++) begin
      chk("R8", "sys_en_o", sys_en_o, 1'b1);
      chk("R8", "pa_en_o", pa_en_o, 1'b1);
      idle(1);
    end
    // R2: every fast bus code, peripherals at 1
    phase = "R2";
    for (int c = 8; c < 16; c++) begin
      wr(2'd0, 4'(c));
      idle(2 * sys_ratio(c) + 3);
    end
    wr(2'd0, 4'd5);      // bit3 clear -> ratio 1
    idle(20);
    // R3: peripheral codes over fast ratio 2
    phase = "R3";
    wr(2'd0, 4'd8);
    for (int c = 0; c < 8; c++) begin
      wr(2'd1, 4'(c));
      wr(2'd2, 4'(7 - c));
      idle(80);
    end
    wr(2'd1, 4'hE);      // bit3 ignored for peripheral: code 6
    idle(60);
    // R5: deep cascade, peripherals count fast strobes
    phase = "R5";
    wr(2'd0, 4'd11);
    wr(2'd1, 4'd7);
    wr(2'd2, 4'd5);
    idle(1200);
    // R7: rewrites inside long periods, last write before boundary wins
    phase = "R7";
    wr(2'd0, 4'd15);
    idle(100);
    wr(2'd0, 4'd9);
    idle(37);
    wr(2'd0, 4'd12);
    wr(2'd1, 4'd4);
    idle(600);
    wr(2'd0, 4'd8);
    wr(2'd0, 4'd15);
    wr(2'd2, 4'd7);
    idle(9000);
    // R9: select 3 changes nothing
    phase = "R9";
    wr(2'd0, 4'd9);
    wr(2'd1, 4'd5);
    wr(2'd2, 4'd6);
    idle(600);
    wr(2'd3, 4'd0);
    wr(2'd3, 4'd15);
    idle(300);
    // R8: back to ratio 1 everywhere
    phase = "R8";
    wr(2'd0, 4'd0);
    wr(2'd1, 4'd0);
    wr(2'd2, 4'd3);
    idle(200);
    chk("R8", "sys_en_o", sys_en_o, 1'b1);
    chk("R8", "pb_en_o", pb_en_o, 1'b1);
    // R1: reset mid-run returns all ratios to 1
    phase = "R1";
    wr(2'd0, 4'd10);
    idle(5);
    rst_ni = 1'b0;
    idle(2);
    chk("R1", "sys_en_o", sys_en_o, 1'b1);
    chk("R1", "pa_en_o", pa_en_o, 1'b1);
    rst_ni = 1'b1;
    idle(20);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule